// File: doc/BRIEF.md
# DMA Engine Control and Status Register Pair

This block holds the two software-visible words that govern one scatter-gather DMA channel: a fixed capability word that describes the channel, and a control/status word. Software reads the capability word to learn whether the channel exists, its direction, its transfer type, its channel number and its buffer size limit. It then uses the control/status word to enable the channel and its interrupt, to watch the run state, and to acknowledge the events that the datapath reports.

The datapath raises single-cycle strobes when a descriptor completes, a descriptor is misaligned, a descriptor fetch fails, a transfer aborts or the descriptor chain ends. Each strobe latches a sticky flag, and the flag stays set until software writes a one to its bit. The OR of the flags is readable as a summary bit and drives the interrupt line when the interrupt is enabled. The control/status word also offers two self-clearing reset commands. One resets the user logic only. The other resets the engine and the user logic together. Each command stays visible until the datapath reports that its reset has finished.

Top module: `dma_eng_csr`

## Requirements
- R1: At window offset 0x0 the capability word reads bit 0 = 1 (present), bit 1 = direction (1 card-to-host), bits 5:4 = type (00 block, 01 packet), bits 15:8 = channel number and bits 29:24 = maximum buffer size. All other bits read 0, and writes to this offset change nothing.
- R2: Bit 0 of the control/status word (offset 0x4) is a read/write interrupt enable. The irq output equals bit 0 AND the summary bit.
- R3: Event strobes latch sticky flags at bit 2 (descriptor done), bit 3 (alignment error), bit 4 (fetch error), bit 5 (abort) and bit 7 (chain end). Bit 1 reads the OR of these flags.
- R4: Writing 1 to a flag bit clears only that flag, and writing 0 leaves it unchanged. Writing 1 to bit 1 clears every flag.
- R5: If a strobe and a clearing write hit the same flag in one cycle, the flag remains set.
- R6: Bit 8 is a read/write channel enable and drives eng_enable.
- R7: Bits 11:10 report dp_state (00 idle, 01 running, 10 waiting). The value 11 reads as 00. While either reset command is pending the field reads 00.
- R8: Bit 12 is set in the cycle after dp_state is 10 with no reset pending. It stays set until a 1 is written to it. A set and a clear in the same cycle leave it set.
- R9: Writing 1 to bit 14 sets the user reset command. The command is readable on bit 14 and on user_rst_req, and it clears when user_rst_done is high. While the command is set, or in the cycle it is written, the channel enable is 0 and writes to bit 8 are ignored.
- R10: Writing 1 to bit 15 sets the full reset command. The command is readable on bit 15 and on full_rst_req, and it clears when full_rst_done is high. It holds the channel enable at 0 in the same way as R9. It clears all event flags and bit 12, and ignores new strobes while it is pending.
- R11: Offsets other than 0x0 and 0x4 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset inside the channel window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ev_bd_done | input | 1 | Descriptor completed strobe |
| ev_align_err | input | 1 | Descriptor alignment error strobe |
| ev_fetch_err | input | 1 | Descriptor fetch error strobe |
| ev_abort | input | 1 | Transfer abort strobe |
| ev_chain_end | input | 1 | Descriptor chain ended strobe |
| dp_state | input | 2 | Datapath run state |
| user_rst_done | input | 1 | User-logic reset finished |
| full_rst_done | input | 1 | Engine and user reset finished |
| irq | output | 1 | Interrupt request |
| eng_enable | output | 1 | Channel enable to the datapath |
| user_rst_req | output | 1 | User-logic reset command |
| full_rst_req | output | 1 | Engine and user reset command |

## Verification
Directed sequences separate the cases that a single pattern would blur. One sequence clears a single flag while others are set, which tells a per-bit clear from a clear-all. Another acknowledges a flag in the same cycle as its strobe, which tells event priority from acknowledge priority. A third writes the enable while a reset is pending, and a fourth raises strobes during a full reset. A long run of random writes, strobes, datapath states and done pulses is then compared every cycle against a bench model. That run exposes wrong combinations of reset commands with acknowledges and state reporting.

// File: rtl/dma_eng_csr.sv
`timescale 1ns/1ps
module dma_eng_csr #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  ENG_NUM  = 8'd0,
  parameter bit          IS_C2H   = 1'b0,
  parameter logic [1:0]  ENG_TYPE = 2'b00,
  parameter logic [5:0]  MAX_BC   = 6'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_bd_done,
  input  logic              ev_align_err,
  input  logic              ev_fetch_err,
  input  logic              ev_abort,
  input  logic              ev_chain_end,
  input  logic [1:0]        dp_state,
  input  logic              user_rst_done,
  input  logic              full_rst_done,
  output logic              irq,
  output logic              eng_enable,
  output logic              user_rst_req,
  output logic              full_rst_req
);
  localparam logic [7:0] EV_MASK = 8'hBE;
  localparam logic [ADDR_W-1:0] OFS_CAP  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);
  localparam logic [31:0] CAP_WORD = {2'b00, MAX_BC, 8'h00, ENG_NUM, 2'b00, ENG_TYPE, 2'b00, IS_C2H, 1'b1};

  logic       ie_q, en_q, wt_q, ur_q, fr_q;
  logic [7:0] flags_q;

  wire        ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
  wire  [7:0] ev_vec   = {ev_chain_end, 1'b0, ev_abort, ev_fetch_err, ev_align_err, ev_bd_done, 2'b00};
  wire  [7:0] ack_m    = !ctrl_wr ? 8'h00 : (reg_wdata[1] ? EV_MASK : (reg_wdata[7:0] & EV_MASK));
  wire        ur_n     = (ctrl_wr && reg_wdata[14]) || (ur_q && !user_rst_done);
  wire        fr_n     = (ctrl_wr && reg_wdata[15]) || (fr_q && !full_rst_done);
  wire        rst_busy = ur_q || fr_q;
  wire        summary  = |flags_q;
  wire  [1:0] st_rep   = (rst_busy || dp_state == 2'b11) ? 2'b00 : dp_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      en_q    <= 1'b0;
      wt_q    <= 1'b0;
      ur_q    <= 1'b0;
      fr_q    <= 1'b0;
      flags_q <= 8'h00;
    end else begin
      ur_q <= ur_n;
      fr_q <= fr_n;
      if (ctrl_wr) ie_q <= reg_wdata[0];
      if (ur_n || fr_n) en_q <= 1'b0;
      else if (ctrl_wr) en_q <= reg_wdata[8];
      if (fr_n) begin
        flags_q <= 8'h00;
        wt_q    <= 1'b0;
      end else begin
        flags_q <= ((flags_q & ~ack_m) | ev_vec) & EV_MASK;
        wt_q    <= (wt_q && !(ctrl_wr && reg_wdata[12])) || (dp_state == 2'b10 && !rst_busy);
      end
    end
  end

  assign irq          = ie_q && summary;
  assign eng_enable   = en_q;
  assign user_rst_req = ur_q;
  assign full_rst_req = fr_q;

  always_comb begin
    reg_rdata = 32'h0;
    if (reg_addr == OFS_CAP)
      reg_rdata = CAP_WORD;
    else if (reg_addr == OFS_CTRL)
      reg_rdata = {16'h0, fr_q, ur_q, 1'b0, wt_q, st_rep, 1'b0, en_q,
                   flags_q[7:2], summary, ie_q};
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bd_done && !fr_n) |=> flags_q[2]); // R5
  AST_RST_ENABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (user_rst_req || full_rst_req) |-> !eng_enable); // R9
  AST_FULL_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_req |-> !irq); // R10
  AST_USER_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (user_rst_req && user_rst_done && !(ctrl_wr && reg_wdata[14])) |=> !user_rst_req); // R9
  AST_WAITED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_q && !(ctrl_wr && reg_wdata[12]) && !fr_n) |=> wt_q); // R8
endmodule

// File: tb/sim_dma_eng_csr.sv
`timescale 1ns/1ps
module sim_dma_eng_csr;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h04;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [4:0]  ev = 5'h0;
  logic [1:0]  dp_state = 2'b00;
  logic        user_rst_done = 1'b0, full_rst_done = 1'b0;
  logic        irq, eng_enable, user_rst_req, full_rst_req;

  dma_eng_csr #(.ADDR_W(8), .ENG_NUM(8'h05), .IS_C2H(1'b1), .ENG_TYPE(2'b01), .MAX_BC(6'd23)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_bd_done(ev[0]), .ev_align_err(ev[1]), .ev_fetch_err(ev[2]),
    .ev_abort(ev[3]), .ev_chain_end(ev[4]), .dp_state(dp_state),
    .user_rst_done(user_rst_done), .full_rst_done(full_rst_done), .irq(irq),
    .eng_enable(eng_enable), .user_rst_req(user_rst_req), .full_rst_req(full_rst_req));

  int checks = 0, fails = 0;
  logic m_ie = 0, m_en = 0, m_wt = 0, m_ur = 0, m_fr = 0;
  logic [7:0] m_fl = 8'h0;

  function automatic logic [31:0] exp_ctrl(input logic [1:0] dp);
    logic [1:0] st;
    st = (m_ur || m_fr || dp == 2'b11) ? 2'b00 : dp;
    return {16'h0, m_fr, m_ur, 1'b0, m_wt, st, 1'b0, m_en, m_fl[7:2], |m_fl, m_ie};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit wr, input logic [7:0] a, input logic [31:0] wd,
                     input logic [4:0] e, input logic [1:0] dp, input bit ud, input bit fd);
    logic cw, ur_n, fr_n;
    logic [7:0] ack, evv;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; ev = e; dp_state = dp;
    user_rst_done = ud; full_rst_done = fd;
    cw   = wr && a == 8'h04;
    evv  = {e[4], 1'b0, e[3], e[2], e[1], e[0], 2'b00};
    ack  = !cw ? 8'h0 : (wd[1] ? 8'hBE : wd[7:0] & 8'hBE);
    ur_n = (cw && wd[14]) || (m_ur && !ud);
    fr_n = (cw && wd[15]) || (m_fr && !fd);
    @(posedge clk);
    #1;
    reg_wr = 1'b0; ev = 5'h0; user_rst_done = 1'b0; full_rst_done = 1'b0;
    if (fr_n) begin
      m_fl = 8'h0; m_wt = 1'b0;
    end else begin
      m_wt = (m_wt && !(cw && wd[12])) || (dp == 2'b10 && !(m_ur || m_fr));
      m_fl = ((m_fl & ~ack) | evv) & 8'hBE;
    end
    if (cw) m_ie = wd[0];
    if (ur_n || fr_n) m_en = 1'b0; else if (cw) m_en = wd[8];
    m_ur = ur_n; m_fr = fr_n;
    reg_addr = 8'h04;
    #1;
    chk(tag, reg_rdata, exp_ctrl(dp));
    chk(tag, {28'h0, irq, eng_enable, user_rst_req, full_rst_req},
        {28'h0, m_ie && (|m_fl), m_en, m_ur, m_fr});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [31:0] wd;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #2;
    chk("reset R6", reg_rdata, 32'h0);
    chk("reset R2", {28'h0, irq, eng_enable, user_rst_req, full_rst_req}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    reg_addr = 8'h00; #1;
    chk("R1 cap", reg_rdata, 32'h17000513);
    cyc("R1 cap write", 1, 8'h00, 32'hFFFFFFFF, 0, 0, 0, 0);
    reg_addr = 8'h00; #1;
    chk("R1 cap after write", reg_rdata, 32'h17000513);
    cyc("R2 ie", 1, 8'h04, 32'h1, 0, 0, 0, 0);
    cyc("R3 bd", 0, 8'h04, 0, 5'b00001, 0, 0, 0);
    chk("R2 irq", {31'h0, irq}, 32'h1);
    cyc("R4 ack one", 1, 8'h04, 32'h5, 0, 0, 0, 0);
    cyc("R3 two ev", 0, 8'h04, 0, 5'b10010, 0, 0, 0);
    cyc("R4 partial", 1, 8'h04, 32'h9, 0, 0, 0, 0);
    chk("R4 chain kept", reg_rdata, 32'h83);
    cyc("R4 clear all", 1, 8'h04, 32'h3, 0, 0, 0, 0);
    cyc("R5 same cycle", 1, 8'h04, 32'h5, 5'b00001, 0, 0, 0);
    chk("R5 flag kept", reg_rdata & 32'h4, 32'h4);
    cyc("R6 enable", 1, 8'h04, 32'h107, 0, 2'b01, 0, 0);
    chk("R7 running", reg_rdata[11:10], 32'h1);
    cyc("R8 waited", 0, 8'h04, 0, 0, 2'b10, 0, 0);
    cyc("R8 still", 0, 8'h04, 0, 0, 2'b00, 0, 0);
    chk("R8 sticky", {31'h0, reg_rdata[12]}, 32'h1);
    cyc("R8 clear", 1, 8'h04, 32'h1101, 0, 2'b00, 0, 0);
    cyc("R7 code3", 0, 8'h04, 0, 0, 2'b11, 0, 0);
    cyc("R9 user rst", 1, 8'h04, 32'h4101, 0, 2'b01, 0, 0);
    chk("R9 enable low", {31'h0, eng_enable}, 32'h0);
    cyc("R9 enable ignored", 1, 8'h04, 32'h101, 0, 2'b01, 0, 0);
    cyc("R7 idle in reset", 0, 8'h04, 0, 0, 2'b10, 0, 0);
    cyc("R9 done", 0, 8'h04, 0, 0, 2'b01, 1, 0);
    chk("R9 cleared", {31'h0, user_rst_req}, 32'h0);
    cyc("R10 pre ev", 0, 8'h04, 0, 5'b00100, 2'b10, 0, 0);
    cyc("R10 full rst", 1, 8'h04, 32'h8101, 0, 0, 0, 0);
    chk("R10 flags clr", reg_rdata & 32'h10BE, 32'h0);
    cyc("R10 ev ignored", 0, 8'h04, 0, 5'b11111, 2'b10, 0, 0);
    cyc("R10 done", 0, 8'h04, 0, 0, 0, 0, 1);
    reg_addr = 8'h08; #1;
    chk("R11 unmapped", reg_rdata, 32'h0);
    cyc("R11 write ignored", 1, 8'h08, 32'hFFFFFFFF, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      wd = $urandom;
      if (($urandom & 7) != 0) wd[15:14] = 2'b00;
      cyc("R3 random", ($urandom & 1) == 1, (($urandom & 7) == 0) ? 8'h00 : 8'h04, wd,
          5'($urandom & $urandom), 2'($urandom), ($urandom & 3) == 0, ($urandom & 3) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule